// File: doc/BRIEF.md
# Configurable Registered Command/Address Buffer

This block sits between a memory controller and the DRAM devices of a module. Each rising clock edge it captures a bus of command and address lines and drives them out again from registers. Two static configuration inputs set how the inputs are laid out on the outputs.

- **Single mode:** 25 inputs each feed one output.
- **Paired mode:** 14 inputs each feed two identical output copies. The block acts either as the lower half or as the upper half of a two-device pair.

Two active-low chip selects save switching power. When both are HIGH at an edge, the data outputs keep their previous values. The chip selects themselves are registered on every edge, so the next stage sees them one cycle later whatever the gating state. An asynchronous active-low reset clears every output at once.

Top module: `cmd_addr_regbuf`

## Requirements
- R1: With `cfg_sel` = 2'b00 (single mode), after an updating edge `q_main[i]` equals `d_in[i]` for all 25 bits, and `q_copy` is all zero.
- R2: With `cfg_sel` = 2'b01 (paired, lower half), after an updating edge both `q_main[13:0]` and `q_copy[13:0]` equal `d_in[13:0]`, and `q_main[24:14]` is zero.
- R3: With `cfg_sel` = 2'b11 (paired, upper half), after an updating edge both `q_main[24:11]` and `q_copy[13:0]` equal `d_in[24:11]`, and `q_main[10:0]` is zero.
- R4: At a rising edge where `cs_dram_n` and `cs_reg_n` are both 1, `q_main` and `q_copy` keep their previous values whatever `d_in` carries.
- R5: At a rising edge where either chip select is 0, `q_main` and `q_copy` load the mapped value of `d_in` on that edge.
- R6: `cs_dram_q` and `cs_reg_q` take the values of `cs_dram_n` and `cs_reg_n` on every rising edge out of reset, including edges where the data outputs hold.
- R7: While `rst_n` is 0, every output is 0. The outputs clear without waiting for a clock edge, and the chip selects have no effect during reset.
- R8: `cfg_sel` = 2'b10 behaves exactly as single mode, as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sel | input | 2 | Topology select; bit 0 = paired, bit 1 = upper half. Static outside reset |
| cs_dram_n | input | 1 | DRAM chip select, active low |
| cs_reg_n | input | 1 | Register chip select, active low |
| d_in | input | 25 | Command/address inputs |
| q_main | output | 25 | Registered primary outputs |
| q_copy | output | 14 | Registered second copies, used in paired mode |
| cs_dram_q | output | 1 | Registered `cs_dram_n` |
| cs_reg_q | output | 1 | Registered `cs_reg_n` |

## Verification
The data-hold gating and the chip-select registration act on the same edge. An edge with both selects HIGH must freeze `q_main` and `q_copy`, yet it must still move `cs_dram_q` and `cs_reg_q`.

The bench provokes this by driving fresh data together with both selects HIGH, in every topology. The next sample must show the old data on the data outputs and the new values 1,1 on the registered selects.

The release from hold is judged on the following edge. On that edge one select returns LOW, and the data must load at once.

// File: rtl/cmd_addr_regbuf.sv
module cmd_addr_regbuf #(
  parameter int DATA_W = 25,
  parameter int PAIR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_sel,
  input  logic              cs_dram_n,
  input  logic              cs_reg_n,
  input  logic [DATA_W-1:0] d_in,
  output logic [DATA_W-1:0] q_main,
  output logic [PAIR_W-1:0] q_copy,
  output logic              cs_dram_q,
  output logic              cs_reg_q
);
  localparam int SKIP_W = DATA_W - PAIR_W;

  logic              paired, upper;
  logic              hold;
  logic [DATA_W-1:0] nxt_main;
  logic [PAIR_W-1:0] nxt_copy;

  assign paired = cfg_sel[0];
  assign upper  = cfg_sel[1];
  assign hold   = cs_dram_n & cs_reg_n;

  always_comb begin
    nxt_main = '0;
    nxt_copy = '0;
    if (!paired) begin
      nxt_main = d_in;
    end else if (!upper) begin
      nxt_main[PAIR_W-1:0] = d_in[PAIR_W-1:0];
      nxt_copy             = d_in[PAIR_W-1:0];
    end else begin
      nxt_main[DATA_W-1:SKIP_W] = d_in[DATA_W-1:SKIP_W];
      nxt_copy                  = d_in[DATA_W-1:SKIP_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_main    <= '0;
      q_copy    <= '0;
      cs_dram_q <= 1'b0;
      cs_reg_q  <= 1'b0;
    end else begin
      cs_dram_q <= cs_dram_n;
      cs_reg_q  <= cs_reg_n;
      if (!hold) begin
        q_main <= nxt_main;
        q_copy <= nxt_copy;
      end
    end
  end
endmodule

// File: rtl/cmd_addr_regbuf_chk.sv
module cmd_addr_regbuf_chk #(
  parameter int DATA_W = 25,
  parameter int PAIR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cfg_sel,
  input logic              cs_dram_n,
  input logic              cs_reg_n,
  input logic [DATA_W-1:0] d_in,
  input logic [DATA_W-1:0] q_main,
  input logic [PAIR_W-1:0] q_copy,
  input logic              cs_dram_q,
  input logic              cs_reg_q
);
  localparam int SKIP_W = DATA_W - PAIR_W;

  a_r1_single_no_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sel[0]) |-> (q_copy == '0));

  a_r1_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sel[0] && !(cs_dram_n && cs_reg_n)) |=> (q_main == $past(d_in)));

  a_r2_lower_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == 2'b01) |->
      (q_copy == q_main[PAIR_W-1:0] && q_main[DATA_W-1:PAIR_W] == '0));

  a_r3_upper_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == 2'b11) |->
      (q_copy == q_main[DATA_W-1:SKIP_W] && q_main[SKIP_W-1:0] == '0));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_dram_n && cs_reg_n) |=> ($stable(q_main) && $stable(q_copy)));

  a_r6_cs_track: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cs_dram_q == $past(cs_dram_n) && cs_reg_q == $past(cs_reg_n)));

  a_r7_reset_clear: assert property (@(negedge clk)
    (!rst_n) |-> (q_main == '0 && q_copy == '0 && !cs_dram_q && !cs_reg_q));
endmodule

bind cmd_addr_regbuf cmd_addr_regbuf_chk #(.DATA_W(DATA_W), .PAIR_W(PAIR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cs_dram_n(cs_dram_n),
  .cs_reg_n(cs_reg_n), .d_in(d_in), .q_main(q_main), .q_copy(q_copy),
  .cs_dram_q(cs_dram_q), .cs_reg_q(cs_reg_q)
);

// File: tb/tb_cmd_addr_regbuf.sv
`timescale 1ns/1ps
module tb_cmd_addr_regbuf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_sel = 2'b00;
  logic        cs_dram_n = 1'b1;
  logic        cs_reg_n = 1'b1;
  logic [24:0] d_in = '0;
  logic [24:0] q_main;
  logic [13:0] q_copy;
  logic        cs_dram_q, cs_reg_q;

  int tests = 0;
  int fails = 0;
  logic [24:0] m_main = '0;
  logic [13:0] m_copy = '0;

  always #2.5 clk = ~clk;

  cmd_addr_regbuf dut (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cs_dram_n(cs_dram_n),
    .cs_reg_n(cs_reg_n), .d_in(d_in), .q_main(q_main), .q_copy(q_copy),
    .cs_dram_q(cs_dram_q), .cs_reg_q(cs_reg_q)
  );

  // {cfg[1:0], cs_dram_n, cs_reg_n, d[24:0]}
  localparam logic [28:0] VEC [0:11] = '{
    {2'b00, 1'b0, 1'b0, 25'h1ABCDEF},
    {2'b00, 1'b1, 1'b1, 25'h0123456},
    {2'b00, 1'b1, 1'b0, 25'h0123456},
    {2'b00, 1'b0, 1'b1, 25'h1FFFFFF},
    {2'b01, 1'b0, 1'b0, 25'h1F3A5C3},
    {2'b01, 1'b1, 1'b1, 25'h0000001},
    {2'b01, 1'b0, 1'b1, 25'h0002AAA},
    {2'b11, 1'b0, 1'b0, 25'h1555555},
    {2'b11, 1'b1, 1'b1, 25'h0AAAAAA},
    {2'b11, 1'b1, 1'b0, 25'h0F0F0F0},
    {2'b10, 1'b0, 1'b0, 25'h1234567},
    {2'b10, 1'b1, 1'b1, 25'h0000000}
  };

  task automatic check(input string req, input logic [24:0] em, input logic [13:0] ec,
                       input logic ed, input logic er);
    tests++;
    if (q_main !== em || q_copy !== ec || cs_dram_q !== ed || cs_reg_q !== er) begin
      fails++;
      $display("FAIL %s: got main=%h copy=%h cs=%b%b, expected main=%h copy=%h cs=%b%b",
               req, q_main, q_copy, cs_dram_q, cs_reg_q, em, ec, ed, er);
    end
  endtask

  function automatic logic [38:0] mapped(input logic [1:0] cfg, input logic [24:0] d);
    case (cfg)
      2'b01:   mapped = {{11'b0, d[13:0]}, d[13:0]};
      2'b11:   mapped = {{d[24:11], 11'b0}, d[24:11]};
      default: mapped = {d, 14'b0};
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got no finish, expected end of run");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [1:0] cur_cfg;
    string tag;
    #1;
    check("R7 reset state", '0, '0, 1'b0, 1'b0);
    @(negedge clk);
    check("R7 reset ignores clock", '0, '0, 1'b0, 1'b0);
    rst_n = 1'b1;
    cur_cfg = 2'b00;

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (VEC[i][28:27] != cur_cfg) begin
        rst_n = 1'b0;
        cfg_sel = VEC[i][28:27];
        cur_cfg = VEC[i][28:27];
        m_main = '0;
        m_copy = '0;
        @(negedge clk);
        rst_n = 1'b1;
      end
      cfg_sel = VEC[i][28:27];
      cs_dram_n = VEC[i][26];
      cs_reg_n = VEC[i][25];
      d_in = VEC[i][24:0];
      if (!(cs_dram_n && cs_reg_n)) {m_main, m_copy} = mapped(cur_cfg, d_in);
      case (cur_cfg)
        2'b00: tag = "R1";
        2'b01: tag = "R2";
        2'b11: tag = "R3";
        default: tag = "R8";
      endcase
      tag = (cs_dram_n && cs_reg_n) ? {tag, " R4 R6 hold"} : {tag, " R5 R6 load"};
      @(negedge clk);
      check(tag, m_main, m_copy, VEC[i][26], VEC[i][25]);
    end

    // R4/R5: hold then release on next edge, single mode after reset
    @(negedge clk);
    rst_n = 1'b0; cfg_sel = 2'b00;
    @(negedge clk);
    rst_n = 1'b1; cs_dram_n = 1'b0; cs_reg_n = 1'b0; d_in = 25'h0F00F00;
    @(negedge clk);
    cs_dram_n = 1'b1; cs_reg_n = 1'b1; d_in = 25'h1111111;
    @(negedge clk);
    check("R4 hold with new data", 25'h0F00F00, '0, 1'b1, 1'b1);
    cs_dram_n = 1'b0;
    @(negedge clk);
    check("R5 release loads at once", 25'h1111111, '0, 1'b0, 1'b1);

    // R7: asynchronous clear mid-cycle, gating ineffective during reset
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    check("R7 async clear", '0, '0, 1'b0, 1'b0);
    cs_dram_n = 1'b0; cs_reg_n = 1'b0; d_in = 25'h1FFFFFF;
    @(negedge clk);
    @(negedge clk);
    check("R7 selects ignored in reset", '0, '0, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule